// File: doc/BRIEF.md
# Byte-Lane FIFO Word Packer

This block is the register-side front end that a serial flash or SPI controller puts between its 32-bit register bus and its byte-wide transmit and receive queues. A bus write to one of the transmit data addresses is split into bytes, and those bytes are pushed into a byte FIFO. The serial shifter drains that FIFO from the other side. A bus read of the receive data address pops bytes that the shifter has deposited in a second byte FIFO and packs them into one 32-bit word.

The number of bytes moved per access depends on the address. The general transmit address and the receive address move a parameterised count: one byte, or a whole word. Three narrow transmit addresses always move exactly one, two or three bytes, which lets software send an odd-length command and address preamble without padding. A byte-order input selects which end of the word is handled first, in both directions.

Each transfer proceeds one byte per clock. While a transfer is in progress, a busy flag is raised and further bus accesses are refused. The shifter side sees each FIFO's head byte together with empty, full and fill-level flags. Each FIFO can be flushed synchronously.

Top module: `spi_word_packer`

## Requirements
- R1: Each FIFO holds at most FIFO_DEPTH bytes (default 32). tx_level and rx_level report the byte count, and full is raised exactly when the count equals the depth. A byte pushed into a full FIFO is dropped, and popping an empty FIFO has no effect.
- R2: A write to address 0x00 pushes XFER_BYTES bytes of bus_wdata (default 4).
- R3: Writes to addresses 0x80, 0x84 and 0x88 push exactly 1, 2 and 3 bytes of bus_wdata, respectively.
- R4: The value of cfg_msb_first when a write is accepted fixes the byte order for that write. When it is 1, the first byte is bits 31:24, followed by 23:16, and so on. When it is 0, the first byte is bits 7:0, followed by 15:8, and so on. tx_byte always shows the oldest byte in the transmit FIFO.
- R5: If the transmit FIFO is full when a byte of a write is due, that byte and every remaining byte of the same word are discarded, and busy falls on the following cycle.
- R6: A read of address 0x04 pops up to XFER_BYTES bytes, stopping early if the receive FIFO is empty. With cfg_msb_first at 1 on acceptance, the k-th popped byte (k from 0) lands in bits [8*(3-k)+7 : 8*(3-k)]. With cfg_msb_first at 0, it lands in bits [8k+7 : 8k].
- R7: Byte lanes of the result that receive no popped byte read as zero.
- R8: An accepted access moves one byte per clock. bus_busy is high from the cycle after acceptance until the transfer ends, and bus_wr and bus_rd are ignored while bus_busy is high. If both are high together, the write wins.
- R9: tx_flush and rx_flush each empty their FIFO on the next clock. tx_flush also cancels the unsent bytes of a write in progress, or a write accepted in the same cycle.
- R10: After a synchronous reset, both FIFOs are empty, bus_busy and bus_rvalid are 0, and bus_rdata is 0.
- R11: A write to any address other than 0x00, 0x80, 0x84 and 0x88 is ignored. It leaves busy low and the FIFO unchanged.
- R12: The end of a read is marked by a one-cycle pulse on bus_rvalid, with the packed word on bus_rdata. bus_rdata holds that word until the next read completes, and a read from an empty FIFO completes with the word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_msb_first | input | 1 | Byte order: 1 = most significant byte first |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_busy | output | 1 | Transfer in progress, requests refused |
| bus_rdata | output | 32 | Packed receive word |
| bus_rvalid | output | 1 | One-cycle pulse: bus_rdata updated |
| tx_flush | input | 1 | Clear transmit FIFO and cancel pending bytes |
| tx_pop | input | 1 | Shifter consumes tx_byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_level | output | 6 | Transmit FIFO byte count |
| rx_flush | input | 1 | Clear receive FIFO |
| rx_push | input | 1 | Shifter deposits rx_byte |
| rx_byte | input | 8 | Received byte |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_level | output | 6 | Receive FIFO byte count |

## Verification
The bench targets several hazards:

- A word written when the transmit FIFO has only two free slots. A design that kept trying after hitting full would stall busy high or slip stale bytes in once the shifter drains.
- Reads that find fewer bytes than a word. These must zero the untouched lanes and must place the single byte at the top lane when most-significant-first is selected. A design that packed from lane 0 regardless would return a shifted word.
- A flush one cycle after a write is accepted, and a second write issued while busy. A design that failed to cancel or to refuse would leave stray bytes in the FIFO.
- A long stretch of mixed writes, reads, pops, pushes and occasional flushes, which exposes any mismatch between the byte ordering and the fill counts over time.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int ADDR_W     = 8;
  localparam int CNT_W      = $clog2(WORD_BYTES + 1);
  localparam int IDX_W      = $clog2(WORD_BYTES);

  localparam logic [ADDR_W-1:0] A_TX_WORD = 8'h00;
  localparam logic [ADDR_W-1:0] A_RX_WORD = 8'h04;
  localparam logic [ADDR_W-1:0] A_TX_B1   = 8'h80;
  localparam logic [ADDR_W-1:0] A_TX_B2   = 8'h84;
  localparam logic [ADDR_W-1:0] A_TX_B3   = 8'h88;

  // lane that the k-th byte of a word occupies for a given byte order
  function automatic logic [IDX_W-1:0] lane_of(input logic msb_first,
                                               input logic [IDX_W-1:0] idx);
    return msb_first ? (IDX_W'(WORD_BYTES - 1) - idx) : idx;
  endfunction
endpackage

// File: rtl/spi_wp_fifo.sv
module spi_wp_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_wp_splitter.sv
module spi_wp_splitter
  import spi_wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [WORD_W-1:0] load_word,
  input  logic              load_msb,
  input  logic              fifo_full,
  output logic              push,
  output logic [7:0]        push_byte,
  output logic              active
);
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sreg;
  logic              msb;

  assign active    = (cnt != '0);
  assign push      = active && !fifo_full && !flush;
  assign push_byte = msb ? sreg[WORD_W-1 -: 8] : sreg[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sreg <= '0;
      msb  <= 1'b0;
    end else if (flush) begin
      cnt <= '0;
    end else if (load) begin
      cnt  <= load_cnt;
      sreg <= load_word;
      msb  <= load_msb;
    end else if (active) begin
      if (fifo_full) begin
        cnt <= '0;
      end else begin
        cnt  <= cnt - CNT_W'(1);
        sreg <= msb ? {sreg[WORD_W-9:0], 8'h00} : {8'h00, sreg[WORD_W-1:8]};
      end
    end
  end
endmodule

// File: rtl/spi_wp_assembler.sv
module spi_wp_assembler
  import spi_wp_pkg::*;
#(
  parameter int XB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_msb,
  input  logic              fifo_empty,
  input  logic [7:0]        fifo_head,
  output logic              pop,
  output logic              active,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] acc, acc_next;
  logic              msb;

  assign active   = (cnt != '0);
  assign pop      = active && !fifo_empty;
  assign acc_next = acc | (WORD_W'(fifo_head) << {lane_of(msb, idx), 3'b000});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      idx    <= '0;
      acc    <= '0;
      msb    <= 1'b0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      if (start) begin
        cnt <= CNT_W'(XB);
        idx <= '0;
        acc <= '0;
        msb <= start_msb;
      end else if (active) begin
        if (!fifo_empty) begin
          acc <= acc_next;
          idx <= idx + IDX_W'(1);
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) begin
            rdata  <= acc_next;
            rvalid <= 1'b1;
          end
        end else begin
          cnt    <= '0;
          rdata  <= acc;
          rvalid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
  import spi_wp_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int XFER_BYTES = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_msb_first,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              bus_busy,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              tx_flush,
  input  logic              tx_pop,
  output logic [7:0]        tx_byte,
  output logic              tx_empty,
  output logic              tx_full,
  output logic [LVL_W-1:0]  tx_level,
  input  logic              rx_flush,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  output logic              rx_empty,
  output logic              rx_full,
  output logic [LVL_W-1:0]  rx_level
);
  logic             tx_active, rx_active;
  logic             wr_hit, wr_load, rd_start;
  logic [CNT_W-1:0] wr_cnt;
  logic             sp_push;
  logic [7:0]       sp_byte;
  logic             as_pop;
  logic [7:0]       rx_head;

  assign bus_busy = tx_active || rx_active;

  always_comb begin
    wr_hit = 1'b1;
    case (bus_addr)
      A_TX_WORD: wr_cnt = CNT_W'(XFER_BYTES);
      A_TX_B1:   wr_cnt = CNT_W'(1);
      A_TX_B2:   wr_cnt = CNT_W'(2);
      A_TX_B3:   wr_cnt = CNT_W'(3);
      default: begin
        wr_cnt = '0;
        wr_hit = 1'b0;
      end
    endcase
  end

  assign wr_load  = bus_wr && !bus_busy && wr_hit;
  assign rd_start = bus_rd && !bus_wr && !bus_busy && (bus_addr == A_RX_WORD);

  spi_wp_splitter u_split (
    .clk       (clk),
    .rst       (rst),
    .flush     (tx_flush),
    .load      (wr_load),
    .load_cnt  (wr_cnt),
    .load_word (bus_wdata),
    .load_msb  (cfg_msb_first),
    .fifo_full (tx_full),
    .push      (sp_push),
    .push_byte (sp_byte),
    .active    (tx_active)
  );

  spi_wp_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .flush     (tx_flush),
    .push      (sp_push),
    .push_data (sp_byte),
    .pop       (tx_pop),
    .head      (tx_byte),
    .empty     (tx_empty),
    .full      (tx_full),
    .level     (tx_level)
  );

  spi_wp_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .flush     (rx_flush),
    .push      (rx_push),
    .push_data (rx_byte),
    .pop       (as_pop),
    .head      (rx_head),
    .empty     (rx_empty),
    .full      (rx_full),
    .level     (rx_level)
  );

  spi_wp_assembler #(.XB(XFER_BYTES)) u_asm (
    .clk        (clk),
    .rst        (rst),
    .start      (rd_start),
    .start_msb  (cfg_msb_first),
    .fifo_empty (rx_empty),
    .fifo_head  (rx_head),
    .pop        (as_pop),
    .active     (rx_active),
    .rdata      (bus_rdata),
    .rvalid     (bus_rvalid)
  );
endmodule

// File: rtl/spi_word_packer_chk.sv
module spi_word_packer_chk
  import spi_wp_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_busy,
  input logic              bus_rvalid,
  input logic              tx_flush,
  input logic              tx_pop,
  input logic              tx_full,
  input logic              tx_empty,
  input logic [LW-1:0]     tx_level,
  input logic              rx_flush,
  input logic              rx_push,
  input logic              rx_full,
  input logic              rx_empty
  );
  p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LW'(DEPTH));

  p_rx_drop_full_r1: assert property (@(posedge clk) disable iff (rst)
    (rx_full && rx_push && !bus_busy && !rx_flush) |=> rx_full);

  p_tx_full_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_full && !tx_pop && !tx_flush) |=> tx_full);

  p_one_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_busy && bus_addr == A_TX_B1 && !tx_flush) |=> bus_busy ##1 !bus_busy);

  p_tx_flush_r9: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> (tx_empty && tx_level == '0));

  p_rx_flush_r9: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> rx_empty);

  p_rvalid_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |=> !bus_rvalid);
endmodule

bind spi_word_packer spi_word_packer_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_busy   (bus_busy),
  .bus_rvalid (bus_rvalid),
  .tx_flush   (tx_flush),
  .tx_pop     (tx_pop),
  .tx_full    (tx_full),
  .tx_empty   (tx_empty),
  .tx_level   (tx_level),
  .rx_flush   (rx_flush),
  .rx_push    (rx_push),
  .rx_full    (rx_full),
  .rx_empty   (rx_empty)
);

// File: tb/spi_word_packer_test.sv
module spi_word_packer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int XB         = 4;

  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_msb_first = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic        bus_busy, bus_rvalid;
  logic [31:0] bus_rdata;
  logic        tx_flush = 0, tx_pop = 0, rx_flush = 0, rx_push = 0;
  logic [7:0]  tx_byte, rx_byte = 0;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic [5:0]  tx_level, rx_level;

  int total = 0, fails = 0, cycles = 0;
  bit cmp_on = 0;

  spi_word_packer uut (
    .clk(clk), .rst(rst), .cfg_msb_first(cfg_msb_first),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_busy(bus_busy), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tx_flush(tx_flush), .tx_pop(tx_pop), .tx_byte(tx_byte),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_level(tx_level),
    .rx_flush(rx_flush), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_level(rx_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  mtx[$];
  logic [7:0]  mrx[$];
  int          mwc = 0, mrc = 0, mri = 0;
  logic [31:0] mws = 0, macc = 0, mrd = 0;
  bit          mwm = 0, mrm = 0, mval = 0;

  always @(posedge clk) begin
    int tsz, rsz, n;
    bit mbusy, dopush, rpop;
    logic [7:0] pb;
    if (rst) begin
      mtx.delete(); mrx.delete();
      mwc = 0; mrc = 0; mri = 0; mws = 0; macc = 0; mrd = 0; mval = 0;
    end else begin
      tsz = mtx.size(); rsz = mrx.size();
      mbusy = (mwc != 0) || (mrc != 0);
      dopush = 0; rpop = 0; pb = 0;
      if (tx_flush) mwc = 0;
      else if (mwc != 0) begin
        if (tsz >= DEPTH) mwc = 0;
        else begin
          dopush = 1;
          pb = mwm ? mws[31:24] : mws[7:0];
          mws = mwm ? (mws << 8) : (mws >> 8);
          mwc--;
        end
      end
      if (tx_flush) mtx.delete();
      else begin
        if (tx_pop && tsz > 0) void'(mtx.pop_front());
        if (dopush) mtx.push_back(pb);
      end
      mval = 0;
      if (mrc != 0) begin
        if (rsz > 0) begin
          rpop = 1;
          macc = macc | (32'(mrx[0]) << (8 * (mrm ? 3 - mri : mri)));
          mri++; mrc--;
          if (mrc == 0) begin mrd = macc; mval = 1; end
        end else begin
          mrc = 0; mrd = macc; mval = 1;
        end
      end
      if (rx_flush) mrx.delete();
      else begin
        if (rpop) void'(mrx.pop_front());
        if (rx_push && rsz < DEPTH) mrx.push_back(rx_byte);
      end
      if (!mbusy) begin
        if (bus_wr) begin
          case (bus_addr)
            8'h00: n = XB;
            8'h80: n = 1;
            8'h84: n = 2;
            8'h88: n = 3;
            default: n = 0;
          endcase
          if (n != 0 && !tx_flush) begin mwc = n; mws = bus_wdata; mwm = cfg_msb_first; end
        end else if (bus_rd && bus_addr == 8'h04) begin
          mrc = XB; mri = 0; macc = 0; mrm = cfg_msb_first;
        end
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R1 tx_level", 32'(tx_level), mtx.size());
      check("R1 rx_level", 32'(rx_level), mrx.size());
      check("R1 tx_full",  32'(tx_full),  32'(mtx.size() == DEPTH));
      check("R1 rx_full",  32'(rx_full),  32'(mrx.size() == DEPTH));
      check("R1 tx_empty", 32'(tx_empty), 32'(mtx.size() == 0));
      check("R1 rx_empty", 32'(rx_empty), 32'(mrx.size() == 0));
      check("R8 busy",     32'(bus_busy), 32'((mwc != 0) || (mrc != 0)));
      check("R12 rvalid",  32'(bus_rvalid), 32'(mval));
      check("R6 rdata",    bus_rdata, mrd);
      if (mtx.size() > 0) check("R4 tx_byte", 32'(tx_byte), 32'(mtx[0]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_idle();
    while (bus_busy) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit msb);
    wait_idle();
    cfg_msb_first = msb; bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    wait_idle();
  endtask

  task automatic rd(input bit msb, output logic [31:0] v);
    wait_idle();
    cfg_msb_first = msb; bus_addr = 8'h04; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    while (!bus_rvalid) @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pop_expect(input string tag, input logic [7:0] exp);
    check(tag, 32'(tx_byte), 32'(exp));
    tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    rx_byte = b; rx_push = 1;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic pulse_flush(input bit tx, input bit rx);
    tx_flush = tx; rx_flush = rx;
    @(negedge clk);
    tx_flush = 0; rx_flush = 0;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000 cycles", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R10: reset state
    check("R10 tx_level", 32'(tx_level), 0);
    check("R10 rx_level", 32'(rx_level), 0);
    check("R10 busy", 32'(bus_busy), 0);
    check("R10 rvalid", 32'(bus_rvalid), 0);
    check("R10 rdata", bus_rdata, 0);
    cmp_on = 1;

    // R2 + R4: general port, LSB first
    wr(8'h00, 32'h44332211, 0);
    check("R2 level after word", 32'(tx_level), 4);
    pop_expect("R4 lsb b0", 8'h11);
    pop_expect("R4 lsb b1", 8'h22);
    pop_expect("R4 lsb b2", 8'h33);
    pop_expect("R4 lsb b3", 8'h44);

    // R3 + R4: narrow ports
    wr(8'h84, 32'hAABBCCDD, 1);
    check("R3 two bytes", 32'(tx_level), 2);
    pop_expect("R4 msb b0", 8'hAA);
    pop_expect("R4 msb b1", 8'hBB);
    wr(8'h88, 32'h00C0B0A0, 0);
    check("R3 three bytes", 32'(tx_level), 3);
    pop_expect("R3 b0", 8'hA0);
    pop_expect("R3 b1", 8'hB0);
    pop_expect("R3 b2", 8'hC0);
    wr(8'h80, 32'h5A000000, 1);
    check("R3 one byte", 32'(tx_level), 1);
    pop_expect("R3 single msb", 8'h5A);

    // R11: unknown address
    wr(8'h40, 32'hFFFFFFFF, 0);
    check("R11 busy", 32'(bus_busy), 0);
    check("R11 level", 32'(tx_level), 0);

    // R5: overflow mid-word
    for (int i = 0; i < 7; i++) wr(8'h00, 32'h03020100, 0);
    wr(8'h84, 32'h00000504, 0);
    check("R5 level 30", 32'(tx_level), 30);
    wr(8'h00, 32'hDDCCBBAA, 0);
    check("R5 level full", 32'(tx_level), 32);
    check("R5 full flag", 32'(tx_full), 1);
    check("R5 busy dropped", 32'(bus_busy), 0);
    tx_pop = 1;
    repeat (30) @(negedge clk);
    tx_pop = 0;
    pop_expect("R5 kept AA", 8'hAA);
    pop_expect("R5 kept BB", 8'hBB);
    check("R5 rest discarded", 32'(tx_empty), 1);

    // R8: write while busy is ignored
    wait_idle();
    cfg_msb_first = 0; bus_addr = 8'h00; bus_wdata = 32'h11111111; bus_wr = 1;
    @(negedge clk);
    bus_addr = 8'h80; bus_wdata = 32'h99;
    @(negedge clk);
    bus_wr = 0;
    wait_idle();
    check("R8 second write ignored", 32'(tx_level), 4);

    // R9: flush, and flush cancelling a write in progress
    pulse_flush(1, 0);
    check("R9 tx flushed", 32'(tx_level), 0);
    cfg_msb_first = 0; bus_addr = 8'h00; bus_wdata = 32'h12345678; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    pulse_flush(1, 0);
    check("R9 cancel level", 32'(tx_level), 0);
    check("R9 cancel busy", 32'(bus_busy), 0);

    // R6: full word reads in both orders
    push_rx(8'h01); push_rx(8'h02); push_rx(8'h03); push_rx(8'h04);
    rd(0, v); check("R6 lsb word", v, 32'h04030201);
    push_rx(8'h01); push_rx(8'h02); push_rx(8'h03); push_rx(8'h04);
    rd(1, v); check("R6 msb word", v, 32'h01020304);

    // R7: short reads zero the untouched lanes
    push_rx(8'hAA); push_rx(8'hBB);
    rd(0, v); check("R7 short lsb", v, 32'h0000BBAA);
    push_rx(8'hCC);
    rd(1, v); check("R7 short msb", v, 32'hCC000000);

    // R12: empty read
    rd(0, v); check("R12 empty read", v, 32'h0);
    check("R12 idle after", 32'(bus_busy), 0);
    @(negedge clk);
    check("R12 pulse ends", 32'(bus_rvalid), 0);
    check("R12 rdata held", bus_rdata, 32'h0);

    // R1: receive overflow, then R9 receive flush
    for (int i = 0; i < 33; i++) push_rx(8'(i));
    check("R1 rx capped", 32'(rx_level), 32);
    check("R1 rx full", 32'(rx_full), 1);
    pulse_flush(0, 1);
    check("R9 rx flushed", 32'(rx_level), 0);

    // mixed traffic against the model
    for (int c = 0; c < 4000; c++) begin
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 5));
      tx_pop = ($urandom_range(0, 2) == 0);
      rx_push = ($urandom_range(0, 2) == 0);
      rx_byte = 8'($urandom);
      cfg_msb_first = 1'($urandom);
      tx_flush = ($urandom_range(0, 90) == 0);
      rx_flush = ($urandom_range(0, 90) == 0);
      bus_wdata = $urandom;
      bus_wr = 0; bus_rd = 0;
      case (sel)
        3'd0: begin bus_wr = 1; bus_addr = 8'h00; end
        3'd1: begin bus_wr = 1; bus_addr = 8'h80; end
        3'd2: begin bus_wr = 1; bus_addr = 8'h84; end
        3'd3: begin bus_wr = 1; bus_addr = 8'h88; end
        3'd4: begin bus_rd = 1; bus_addr = 8'h04; end
        default: begin bus_wr = 1; bus_addr = 8'h0C; end
      endcase
      @(negedge clk);
    end
    bus_wr = 0; bus_rd = 0; tx_pop = 0; rx_push = 0; tx_flush = 0; rx_flush = 0;
    repeat (8) @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule